// File: doc/BRIEF.md
# Load-Store Alignment Unit

This unit connects a 32-bit register datapath to a byte-addressed, word-wide data memory. For each request it adds a signed byte offset to a base register value to form the effective address. It then presents the containing word address to memory, together with per-lane write strobes and write data that has been steered onto the correct lanes. On loads it picks the addressed lane out of the returned word and extends it to 32 bits, with sign or zero fill chosen by the operation.

Memory is byte-addressed: consecutive words lie 4 addresses apart. Lanes are numbered big-endian, so address bits 1:0 = 00 name bits 31:24 of a memory word and 11 names bits 7:0. A word access whose effective address is not a multiple of 4 is refused. It writes nothing and raises a fault. Memory read latency is one cycle, so load results, the valid strobe and the fault flag all appear one cycle after the request.

Operation codes on `req_op`: 0 = word load, 1 = signed byte load, 2 = unsigned byte load, 3 = word store, 4 = byte store, 5 to 7 = reserved (no operation).

Top module: `lsu_align`

## Requirements
- R1: While `req_valid` is high, `mem_addr` equals base plus the sign-extended offset, with bits 1:0 forced to 0.
- R2: An aligned word load (op 0) raises `load_valid` one cycle later, and `load_data` then equals the full 32-bit word that memory returned.
- R3: A signed byte load (op 1) returns the addressed byte in bits 7:0, where address bits 1:0 = 00 select memory bits 31:24 and 11 select bits 7:0. Bits 31:8 are copies of that byte's bit 7.
- R4: An unsigned byte load (op 2) returns the same byte in bits 7:0 with bits 31:8 all zero.
- R5: An aligned word store (op 3) drives `mem_we` = 1111 and `mem_wdata` = `store_data` in the request cycle.
- R6: A byte store (op 4) drives `store_data[7:0]` onto all four lanes of `mem_wdata` and sets exactly one `mem_we` bit: bit 3 for address bits 00, bit 2 for 01, bit 1 for 10, bit 0 for 11.
- R7: A word load or store whose effective address has non-zero bits 1:0 drives `mem_we` = 0 and `mem_re` = 0. It raises `align_fault` for exactly the following cycle. If it is a load, `load_valid` is high in that cycle with `load_data` = 0.
- R8: Byte loads and byte stores never raise `align_fault`, whatever the address bits 1:0.
- R9: With `req_valid` low, or with a reserved op code, `mem_we` and `mem_re` are 0, and `load_valid` and `align_fault` stay low in the next cycle.
- R10: During and right after reset, `load_valid`, `align_fault` and `load_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| base | input | 32 | Base register value |
| offset | input | OFF_W | Signed byte offset |
| store_data | input | 32 | Source register value for stores |
| mem_addr | output | 32 | Word address to memory (bits 1:0 zero) |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 4 | Per-lane write enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data to memory |
| mem_rdata | input | 32 | Read data from memory, one cycle after `mem_re` |
| load_data | output | 32 | Extended load result |
| load_valid | output | 1 | Load result valid |
| align_fault | output | 1 | Misaligned word access seen in previous cycle |

## Verification
A fixed word with bytes 80, 7F, FF and 01 is read at every lane with both byte loads. This separates sign fill from zero fill, and it exposes any mistake in big-endian lane selection. Word loads and stores are run at all four address phases, so the aligned case can be told apart from each misaligned case, and the test confirms that a refused store leaves memory untouched. Byte stores at each lane are followed by word loads, which show that the other three bytes were kept. A long random mix of operations, full-range bases and negative offsets checks the address sum and the wrap into the sign-extended offset.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter int OFF_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [31:0]      base,
  input  logic [OFF_W-1:0] offset,
  input  logic [31:0]      store_data,
  output logic [31:0]      mem_addr,
  output logic             mem_re,
  output logic [3:0]       mem_we,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic [31:0]      load_data,
  output logic             load_valid,
  output logic             align_fault
);
  localparam int NLANE = 4;
  localparam logic [2:0] OP_LDW = 3'd0, OP_LDB = 3'd1, OP_LDBU = 3'd2,
                         OP_STW = 3'd3, OP_STB = 3'd4;

  logic [31:0] eff;
  logic [1:0]  lane;
  logic        is_word, is_load, misal;
  logic [NLANE-1:0] lane_hit;

  assign eff     = base + {{(32-OFF_W){offset[OFF_W-1]}}, offset};
  assign lane    = eff[1:0];
  assign is_word = (req_op == OP_LDW) || (req_op == OP_STW);
  assign is_load = (req_op == OP_LDW) || (req_op == OP_LDB) || (req_op == OP_LDBU);
  assign misal   = is_word && (lane != 2'b00);

  for (genvar g = 0; g < NLANE; g++) begin : g_hit
    assign lane_hit[g] = (lane == 2'(NLANE-1-g));
  end

  assign mem_addr  = {eff[31:2], 2'b00};
  assign mem_re    = req_valid && is_load && !misal;
  assign mem_wdata = (req_op == OP_STB) ? {NLANE{store_data[7:0]}} : store_data;

  always_comb begin
    mem_we = '0;
    if (req_valid && !misal) begin
      if (req_op == OP_STW)      mem_we = '1;
      else if (req_op == OP_STB) mem_we = lane_hit;
    end
  end

  logic       vld_q, flt_q;
  logic [2:0] op_q;
  logic [1:0] lane_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      flt_q  <= 1'b0;
      op_q   <= OP_LDW;
      lane_q <= 2'b00;
    end else begin
      vld_q  <= req_valid && is_load;
      flt_q  <= req_valid && misal;
      op_q   <= req_op;
      lane_q <= lane;
    end
  end

  logic [7:0] rd_lane [NLANE];
  for (genvar g = 0; g < NLANE; g++) begin : g_rd
    assign rd_lane[g] = mem_rdata[8*(NLANE-1-g) +: 8];
  end

  logic [7:0] rd_byte;
  assign rd_byte = rd_lane[lane_q];

  always_comb begin
    load_data = '0;
    if (vld_q && !flt_q) begin
      case (op_q)
        OP_LDW:  load_data = mem_rdata;
        OP_LDB:  load_data = {{24{rd_byte[7]}}, rd_byte};
        default: load_data = {24'h0, rd_byte};
      endcase
    end
  end

  assign load_valid  = vld_q;
  assign align_fault = flt_q;
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int OFF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [31:0]      base,
  input logic [OFF_W-1:0] offset,
  input logic [31:0]      mem_addr,
  input logic             mem_re,
  input logic [3:0]       mem_we,
  input logic [31:0]      load_data,
  input logic             load_valid,
  input logic             align_fault
);
  logic [31:0] sum;
  logic        word_op, byte_op, bad_word;
  assign sum      = base + 32'($signed(offset));
  assign word_op  = (req_op == 3'd0) || (req_op == 3'd3);
  assign byte_op  = (req_op == 3'd1) || (req_op == 3'd2) || (req_op == 3'd4);
  assign bad_word = req_valid && word_op && (sum[1:0] != 2'b00);

  p_addr_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> mem_addr == {sum[31:2], 2'b00});
  p_lbu_zero_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2) |=> (load_valid && load_data[31:8] == 24'h0));
  p_sb_one_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4) |-> $countones(mem_we) == 1);
  p_misal_no_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_word |-> (mem_we == 4'h0 && !mem_re));
  p_misal_fault_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad_word |=> (align_fault && load_data == 32'h0));
  p_byte_no_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && byte_op) |=> !align_fault);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (mem_we == 4'h0 && !mem_re));
  p_idle_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!load_valid && !align_fault));
endmodule

bind lsu_align lsu_align_chk #(.OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
  .base(base), .offset(offset), .mem_addr(mem_addr), .mem_re(mem_re),
  .mem_we(mem_we), .load_data(load_data), .load_valid(load_valid),
  .align_fault(align_fault)
);

// File: tb/lsu_align_bench.sv
`timescale 1ns/1ps
module lsu_align_bench;
  localparam int OFF_W = 16;
  localparam int NW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [31:0] base = '0, store_data = '0;
  logic [OFF_W-1:0] offset = '0;
  logic [31:0] mem_addr, mem_wdata, load_data;
  logic [31:0] mem_rdata = '0;
  logic mem_re, load_valid, align_fault;
  logic [3:0] mem_we;

  always #2.5 clk = ~clk;

  lsu_align #(.OFF_W(OFF_W)) u_lsu_align (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .base(base), .offset(offset), .store_data(store_data),
    .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .load_data(load_data),
    .load_valid(load_valid), .align_fault(align_fault)
  );

  logic [31:0] mem [NW];
  logic [31:0] model [NW];

  always @(posedge clk) begin
    mem_rdata <= mem[mem_addr[5:2]];
    for (int b = 0; b < 4; b++)
      if (mem_we[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input logic [31:0] w, input logic [1:0] ln);
    return w[8*(3-ln) +: 8];
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic do_op(input bit v, input logic [2:0] op, input logic [31:0] b,
                       input logic [OFF_W-1:0] off, input logic [31:0] sd);
    logic [31:0] eff, w, exp_ld;
    logic [3:0] exp_we;
    logic [1:0] ln;
    logic [3:0] idx;
    bit word, ld, bad;
    req_valid = v; req_op = op; base = b; offset = off; store_data = sd;
    #1;
    eff  = b + {{(32-OFF_W){off[OFF_W-1]}}, off};
    ln   = eff[1:0];
    idx  = eff[5:2];
    word = (op == 3'd0) || (op == 3'd3);
    ld   = v && (op <= 3'd2);
    bad  = v && word && (ln != 2'b00);
    exp_we = 4'h0;
    if (v && !bad && op == 3'd3) exp_we = 4'hF;
    if (v && op == 3'd4) exp_we = 4'b1000 >> ln;
    if (v) check("R1 addr", mem_addr, {eff[31:2], 2'b00});
    check(bad ? "R7 we" : (v ? tag_of(op) : "R9 we"), {28'h0, mem_we}, {28'h0, exp_we});
    check(bad ? "R7 re" : "R9 re", {31'h0, mem_re}, {31'h0, ld && !bad});
    if (exp_we == 4'hF) check("R5 wdata", mem_wdata, sd);
    if (v && op == 3'd4) check("R6 wdata", mem_wdata, {4{sd[7:0]}});
    w = model[idx];
    exp_ld = 32'h0;
    if (ld && !bad) begin
      case (op)
        3'd0: exp_ld = w;
        3'd1: exp_ld = {{24{pick(w, ln)[7]}}, pick(w, ln)};
        default: exp_ld = {24'h0, pick(w, ln)};
      endcase
    end
    for (int k = 0; k < 4; k++)
      if (exp_we[k]) model[idx][8*k +: 8] = sd[8*k +: 8] & 8'hFF;
    if (exp_we != 0 && op == 3'd4)
      for (int k = 0; k < 4; k++) if (exp_we[k]) model[idx][8*k +: 8] = sd[7:0];
    @(negedge clk);
    check(ld ? tag_of(op) : "R9 valid", {31'h0, load_valid}, {31'h0, ld});
    check(bad ? "R7 fault" : (v && !word && op <= 3'd4 ? "R8 fault" : "R9 fault"),
          {31'h0, align_fault}, {31'h0, bad});
    check(bad ? "R7 data" : tag_of(op), load_data, exp_ld);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < NW; i++) begin
      mem[i] = 32'hA5C3_0F81 ^ (32'h0101_0101 * i);
      model[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check("R10 valid", {31'h0, load_valid}, 32'h0);
    check("R10 fault", {31'h0, align_fault}, 32'h0);
    check("R10 data", load_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 data", load_data, 32'h0);

    do_op(1, 3'd3, 32'h0000_0008, 16'h0008, 32'h807F_FF01);
    for (int l = 0; l < 4; l++) begin
      do_op(1, 3'd1, 32'h0000_0010, 16'(l), 32'h0);
      do_op(1, 3'd2, 32'h0000_0010, 16'(l), 32'h0);
    end
    for (int l = 1; l < 4; l++) begin
      do_op(1, 3'd0, 32'h0000_0010, 16'(l), 32'h0);
      do_op(1, 3'd3, 32'h0000_0014, 16'(l), 32'hDEAD_BEEF);
    end
    do_op(1, 3'd0, 32'h0000_0014, 16'h0000, 32'h0);
    for (int l = 0; l < 4; l++) begin
      do_op(1, 3'd4, 32'h0000_0020, 16'(l), 32'h1234_5600 | 32'(l + 8'hC0));
      do_op(1, 3'd0, 32'h0000_0020, 16'h0000, 32'h0);
    end
    do_op(1, 3'd0, 32'h0000_0030, 16'hFFF0, 32'h0);
    do_op(1, 3'd5, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFF);
    do_op(1, 3'd7, 32'h0000_0004, 16'h0000, 32'hFFFF_FFFF);
    do_op(0, 3'd3, 32'h0000_0004, 16'h0000, 32'hFFFF_FFFF);
    do_op(1, 3'd0, 32'h0000_0004, 16'h0000, 32'h0);

    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 6);
      do_op(($urandom % 8) != 0, op, $urandom, 16'($urandom), $urandom);
    end
    req_valid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule